// File: doc/BRIEF.md
# Control Register Update Controller

This block holds the three paging-related control registers of an x86-style core (CR0, CR3 and CR4) together with the gate on address line 20. A single write port, steered by a register select, loads one control register per cycle. On each write the block compares chosen bit groups of the old and new value and decides whether the address translation cache must be flushed entirely, flushed of its non-global entries only, or left alone. A separate level input carries the requested state of address line 20; whenever it differs from the current gate the block asks the execution engine to leave its current code block, flushes the translation cache and rebuilds the address mask.

As side effects of CR0 writes, the block keeps a set of hidden mode flags used elsewhere in the core: a protected-mode flag, an add-segment-base flag, and the three floating-point control flags. All state is loaded with its reset value on a synchronous, active-high reset. Flush and exit requests are single-cycle pulses issued in the cycle after the event that caused them.

Top module: `crx_update_unit`

## Requirements
- R1: After reset, CR0 reads 0x60000010, CR3 and CR4 read 0, the A20 mask reads 0xFFFFFFFF, all three pulses are low, the protected-mode flag is 0, the add-segment-base flag is 1 and the MP, EM and TS flags are 0.
- R2: A write with select 0 stores the data into CR0 with bit 4 forced to 1.
- R3: A CR0 write pulses the full flush output if and only if bit 31, bit 16 or bit 0 differs between the old and new CR0.
- R4: A write with select 1 always stores the data into CR3; it pulses the non-global flush output if and only if CR0 bit 31 is set at the time of the write.
- R5: A write with select 2 stores the data into CR4 and pulses the full flush output if and only if bit 7, bit 5 or bit 4 differs between the old and new CR4.
- R6: When the A20 enable input differs from bit 20 of the current mask, the block pulses the exit request and the full flush output and loads the mask with 0xFFEFFFFF, bit 20 taking the new input value.
- R7: While the A20 enable input equals bit 20 of the mask, no exit request is raised and the mask does not change.
- R8: After a CR0 write the protected-mode flag equals the new CR0 bit 0 and the add-segment-base flag is its complement, so it is 1 whenever protected mode is off.
- R9: After a CR0 write the MP, EM and TS flags equal written data bits 1, 2 and 3 respectively.
- R10: Every pulse is high for exactly the one cycle after the write strobe or A20 change that caused it; a write with select 3 changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for one control register |
| wrSel | input | 2 | Register select: 0 CR0, 1 CR3, 2 CR4, 3 none |
| wrData | input | 32 | Value to write |
| a20En | input | 1 | Requested state of address line 20 |
| cr0Out | output | 32 | Current CR0 |
| cr3Out | output | 32 | Current CR3 |
| cr4Out | output | 32 | Current CR4 |
| a20Mask | output | 32 | Current physical address mask |
| flushAll | output | 1 | Full translation cache flush pulse |
| flushLocal | output | 1 | Non-global translation cache flush pulse |
| exitReq | output | 1 | Request to leave the executing code block |
| hPe | output | 1 | Hidden protected-mode flag |
| hAddSeg | output | 1 | Hidden add-segment-base flag |
| hMp | output | 1 | Hidden FPU monitor flag |
| hEm | output | 1 | Hidden FPU emulation flag |
| hTs | output | 1 | Hidden FPU task-switched flag |

## Verification
Every result of this block, register contents, hidden flags, mask and pulses alike, is due exactly one clock edge after the write strobe or A20 change that causes it, since the decision logic is combinational and only the datapath registers lie on the path. The bench drives each stimulus on a falling edge, waits for the next rising edge and samples on the falling edge that follows, where the pulse of that stimulus must be high; withdrawing the strobe at that same falling edge lets the following sample confirm the pulse has dropped.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR3  = 2'd1,
    SEL_CR4  = 2'd2,
    SEL_NONE = 2'd3
  } crSel_e;

  localparam logic [DATA_W-1:0] CR0_RESET   = 32'h6000_0010;
  localparam logic [DATA_W-1:0] CR0_ET      = 32'h0000_0010;
  localparam logic [DATA_W-1:0] CR0_PAGING  = 32'h8001_0001;
  localparam logic [DATA_W-1:0] CR4_PAGING  = 32'h0000_00B0;
  localparam int                CR0_PG_BIT  = 31;
  localparam int                A20_BIT     = 20;

  typedef struct packed {
    logic ldCr0;
    logic ldCr3;
    logic ldCr4;
    logic ldA20;
    logic fullFlush;
    logic localFlush;
    logic exitBlk;
  } crStrobe_t;
endpackage

// File: rtl/crx_ctrl.sv
module crx_ctrl
  import crx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic [W-1:0] wrData,
  input  logic         a20En,
  input  logic [W-1:0] cr0Cur,
  input  logic [W-1:0] cr4Cur,
  input  logic         a20Cur,
  output crStrobe_t    stb
);
  logic cr0Diff;
  logic cr4Diff;
  logic a20Change;

  assign cr0Diff   = |((cr0Cur ^ wrData) & CR0_PAGING);
  assign cr4Diff   = |((cr4Cur ^ wrData) & CR4_PAGING);
  assign a20Change = (a20En != a20Cur);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (crSel_e'(wrSel))
        SEL_CR0: begin
          stb.ldCr0     = 1'b1;
          stb.fullFlush = cr0Diff;
        end
        SEL_CR3: begin
          stb.ldCr3      = 1'b1;
          stb.localFlush = cr0Cur[CR0_PG_BIT];
        end
        SEL_CR4: begin
          stb.ldCr4     = 1'b1;
          stb.fullFlush = cr4Diff;
        end
        default: ;
      endcase
    end
    if (a20Change) begin
      stb.ldA20     = 1'b1;
      stb.exitBlk   = 1'b1;
      stb.fullFlush = 1'b1;
    end
  end
endmodule

// File: rtl/crx_datapath.sv
module crx_datapath
  import crx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  crStrobe_t    stb,
  input  logic [W-1:0] wrData,
  input  logic         a20En,
  output logic [W-1:0] cr0Q,
  output logic [W-1:0] cr3Q,
  output logic [W-1:0] cr4Q,
  output logic [W-1:0] maskQ,
  output logic         fullQ,
  output logic         localQ,
  output logic         exitQ,
  output logic         peQ,
  output logic         addSegQ,
  output logic [2:0]   fpuQ
);
  localparam logic [W-1:0] A20_CLR = ~(W'(1) << A20_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0Q    <= CR0_RESET;
      cr3Q    <= '0;
      cr4Q    <= '0;
      maskQ   <= '1;
      fullQ   <= 1'b0;
      localQ  <= 1'b0;
      exitQ   <= 1'b0;
      peQ     <= CR0_RESET[0];
      addSegQ <= ~CR0_RESET[0];
      fpuQ    <= CR0_RESET[3:1];
    end else begin
      fullQ  <= stb.fullFlush;
      localQ <= stb.localFlush;
      exitQ  <= stb.exitBlk;
      if (stb.ldCr0) begin
        cr0Q    <= wrData | CR0_ET;
        peQ     <= wrData[0];
        addSegQ <= ~wrData[0];
        fpuQ    <= wrData[3:1];
      end
      if (stb.ldCr3) cr3Q <= wrData;
      if (stb.ldCr4) cr4Q <= wrData;
      if (stb.ldA20) maskQ <= A20_CLR | (W'(a20En) << A20_BIT);
    end
  end
endmodule

// File: rtl/crx_update_unit.sv
module crx_update_unit
  import crx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [31:0] wrData,
  input  logic        a20En,
  output logic [31:0] cr0Out,
  output logic [31:0] cr3Out,
  output logic [31:0] cr4Out,
  output logic [31:0] a20Mask,
  output logic        flushAll,
  output logic        flushLocal,
  output logic        exitReq,
  output logic        hPe,
  output logic        hAddSeg,
  output logic        hMp,
  output logic        hEm,
  output logic        hTs
);
  crStrobe_t  stb;
  logic [2:0] fpu;

  crx_ctrl #(.W(DATA_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .a20En  (a20En),
    .cr0Cur (cr0Out),
    .cr4Cur (cr4Out),
    .a20Cur (a20Mask[A20_BIT]),
    .stb    (stb)
  );

  crx_datapath #(.W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrData  (wrData),
    .a20En   (a20En),
    .cr0Q    (cr0Out),
    .cr3Q    (cr3Out),
    .cr4Q    (cr4Out),
    .maskQ   (a20Mask),
    .fullQ   (flushAll),
    .localQ  (flushLocal),
    .exitQ   (exitReq),
    .peQ     (hPe),
    .addSegQ (hAddSeg),
    .fpuQ    (fpu)
  );

  assign hMp = fpu[0];
  assign hEm = fpu[1];
  assign hTs = fpu[2];
endmodule

// File: rtl/crx_checker.sv
module crx_checker (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic [31:0] wrData,
  input logic        a20En,
  input logic [31:0] cr0Out,
  input logic [31:0] cr4Out,
  input logic [31:0] a20Mask,
  input logic        flushAll,
  input logic        flushLocal,
  input logic        exitReq,
  input logic        hPe,
  input logic        hAddSeg,
  input logic        hMp,
  input logic        hEm,
  input logic        hTs
);
  AST_CR0_STORE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd0) |=> cr0Out == ($past(wrData) | 32'h10)); // R2

  AST_CR0_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd0 && ((cr0Out ^ wrData) & 32'h8001_0001) != 0) |=> flushAll); // R3

  AST_CR3_NOPG: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd1 && !cr0Out[31]) |=> !flushLocal); // R4

  AST_CR4_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd2 && ((cr4Out ^ wrData) & 32'h0000_00B0) != 0) |=> flushAll); // R5

  AST_A20_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (a20En != a20Mask[20]) |=> (exitReq && flushAll && a20Mask[20] == $past(a20En))); // R6

  AST_A20_HOLD: assert property (@(posedge clk) disable iff (rst)
    (a20En == a20Mask[20]) |=> (!exitReq && $stable(a20Mask))); // R7

  AST_MODE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd0) |=> (hPe == $past(wrData[0]) && hAddSeg == !$past(wrData[0]))); // R8

  AST_FPU_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd0) |=> ({hTs, hEm, hMp} == $past(wrData[3:1]))); // R9

  AST_NO_SEL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wrSel == 2'd3 && a20En == a20Mask[20]) |=> (!flushAll && !flushLocal && !exitReq)); // R10
endmodule

bind crx_update_unit crx_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .a20En      (a20En),
  .cr0Out     (cr0Out),
  .cr4Out     (cr4Out),
  .a20Mask    (a20Mask),
  .flushAll   (flushAll),
  .flushLocal (flushLocal),
  .exitReq    (exitReq),
  .hPe        (hPe),
  .hAddSeg    (hAddSeg),
  .hMp        (hMp),
  .hEm        (hEm),
  .hTs        (hTs)
);

// File: tb/test_crx_update_unit.sv
`timescale 1ns/1ps
module test_crx_update_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic        a20En = 1'b1;
  logic [31:0] cr0Out, cr3Out, cr4Out, a20Mask;
  logic        flushAll, flushLocal, exitReq, hPe, hAddSeg, hMp, hEm, hTs;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crx_update_unit i_crx_update_unit (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .a20En(a20En),
    .cr0Out(cr0Out), .cr3Out(cr3Out), .cr4Out(cr4Out), .a20Mask(a20Mask),
    .flushAll(flushAll), .flushLocal(flushLocal), .exitReq(exitReq),
    .hPe(hPe), .hAddSeg(hAddSeg), .hMp(hMp), .hEm(hEm), .hTs(hTs)
  );

  typedef struct packed {
    logic        en;
    logic [1:0]  sel;
    logic [31:0] data;
    logic        a20;
    logic        eFull;
    logic        eLocal;
    logic        eExit;
    logic [31:0] eReg;
    logic [31:0] eMask;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 32'h6000_0010, 1'b1, 1'b0, 1'b0, 1'b0, 32'h6000_0010, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0011, 32'hFFFF_FFFF},
    '{1'b1, 2'd1, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 32'h8001_0001, 1'b1, 1'b1, 1'b0, 1'b0, 32'h8001_0011, 32'hFFFF_FFFF},
    '{1'b1, 2'd1, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_2000, 32'hFFFF_FFFF},
    '{1'b1, 2'd2, 32'h0000_0010, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0010, 32'hFFFF_FFFF},
    '{1'b1, 2'd2, 32'h0000_0013, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0013, 32'hFFFF_FFFF},
    '{1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 32'h8001_0011, 32'hFFEF_FFFF},
    '{1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8001_0011, 32'hFFEF_FFFF},
    '{1'b0, 2'd0, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8001_0011, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 32'h8001_000F, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8001_001F, 32'hFFFF_FFFF},
    '{1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8001_001F, 32'hFFFF_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [1:0] sel, input logic [31:0] d, input logic a20);
    wrEn = en; wrSel = sel; wrData = d; a20En = a20;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] pickReg(input logic [1:0] sel);
    case (sel)
      2'd1:    return cr3Out;
      2'd2:    return cr4Out;
      default: return cr0Out;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 cr0", cr0Out, 32'h6000_0010);
    check("R1 cr3", cr3Out, 32'h0);
    check("R1 cr4", cr4Out, 32'h0);
    check("R1 mask", a20Mask, 32'hFFFF_FFFF);
    check("R1 pulses", {29'd0, flushAll, flushLocal, exitReq}, 32'h0);
    check("R1 flags", {27'd0, hPe, hAddSeg, hTs, hEm, hMp}, 32'h0000_0008);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].en, VECS[i].sel, VECS[i].data, VECS[i].a20);
      // R2 R4 R5 register contents, R3 R5 R6 full flush
      check($sformatf("R2/R4/R5 reg vec %0d", i), pickReg(VECS[i].sel), VECS[i].eReg);
      check($sformatf("R3/R5/R6 flushAll vec %0d", i), {31'd0, flushAll}, {31'd0, VECS[i].eFull});
      check($sformatf("R4 flushLocal vec %0d", i), {31'd0, flushLocal}, {31'd0, VECS[i].eLocal});
      check($sformatf("R6/R7 exitReq vec %0d", i), {31'd0, exitReq}, {31'd0, VECS[i].eExit});
      check($sformatf("R6/R7 mask vec %0d", i), a20Mask, VECS[i].eMask);
    end

    // R10 select 3 left CR3/CR4 untouched
    check("R10 cr3 kept", cr3Out, 32'h0000_2000);
    check("R10 cr4 kept", cr4Out, 32'h0000_0013);
    // R8 R9 flags after 0x8001000F
    check("R8 pe on", {30'd0, hPe, hAddSeg}, 32'h2);
    check("R9 fpu flags", {29'd0, hTs, hEm, hMp}, 32'h7);

    // R8 R3 back to real mode: PG WP PE change, ET forced
    step(1'b1, 2'd0, 32'h0000_0004, 1'b1);
    check("R2 et forced", cr0Out, 32'h0000_0014);
    check("R3 flush leaving paging", {31'd0, flushAll}, 32'h1);
    check("R8 pe off", {30'd0, hPe, hAddSeg}, 32'h1);
    check("R9 em only", {29'd0, hTs, hEm, hMp}, 32'h2);
    // R10 pulse lasts one cycle
    @(posedge clk);
    @(negedge clk);
    check("R10 pulse dropped", {29'd0, flushAll, flushLocal, exitReq}, 32'h0);

    // R4 CR3 stored without paging, no local flush
    step(1'b1, 2'd1, 32'hABCD_E000, 1'b1);
    check("R4 cr3 no pg", cr3Out, 32'hABCD_E000);
    check("R4 no local flush", {31'd0, flushLocal}, 32'h0);

    // R5 PGE bit change alone
    step(1'b1, 2'd2, 32'h0000_0093, 1'b1);
    check("R5 pge flush", {31'd0, flushAll}, 32'h1);

    // R6 A20 change together with a CR3 write
    step(1'b1, 2'd1, 32'h0000_5000, 1'b0);
    check("R6 exit with write", {30'd0, exitReq, flushAll}, 32'h3);
    check("R6 mask with write", a20Mask, 32'hFFEF_FFFF);
    check("R4 cr3 with a20", cr3Out, 32'h0000_5000);

    // R1 synchronous reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    a20En = 1'b1;
    rst = 1'b0;
    check("R1 re-reset cr0", cr0Out, 32'h6000_0010);
    check("R1 re-reset mask", a20Mask, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule